// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer

This block sits on the host side of a byte-wide parallel EEPROM that has a 32-byte page. A command carries a start address, a write/read selector and, for writes, a byte count. Write data then arrives as a stream over a valid/ready handshake. The block turns the command into chip-enable, output-enable and write-enable pulses on the memory pins. Every width is a whole number of clock cycles, so each nanosecond limit is rounded up for the chosen clock.

During a write, each byte is latched into the device by one write-enable low pulse. The address and data stay fixed for the whole pulse, and output-enable stays high. Successive pulses are spaced at least a minimum interval apart. If the stream stalls for longer than the device's byte-load window allows, the block stops loading. After the last load it waits a settle time and then polls the ready/busy pin until the device reports ready, or until a timeout expires. A read command holds chip-enable and output-enable low for an access time and then captures the data bus.

The block never wraps inside a page. If a write reaches the last byte of a page while bytes remain, the block stops there and flags the error.

Top module: `eeprom_page_prog`

## Requirements
- R1: While reset is asserted, and on its release, mem_ce_n, mem_oe_n and mem_we_n are high, mem_dout_en is low, cmd_ready is high, and done, rd_valid and all three error flags are low.
- R2: Each accepted write byte is loaded by one mem_we_n low pulse of exactly WE_LOW_CYC cycles. During the pulse mem_ce_n is low, mem_oe_n is high, mem_dout_en is high, mem_dout holds the byte and mem_addr stays stable. The n-th byte (counting from 0) goes to start address + n.
- R3: Between two loads of the same command, mem_we_n stays high for at least WE_HIGH_CYC cycles.
- R4: cmd_len encodes the byte count minus one, so a value of 0 means 1 byte and a value of 31 means 32 bytes. A write with no page or stall error produces exactly cmd_len+1 load pulses.
- R5: If a byte is loaded at page offset 31 (address bits [4:0] all ones) while bytes remain, loading stops and err_page is set. Every load of a command uses the same address bits [12:5].
- R6: After the first byte, if no byte is offered within GAP_MAX_CYC cycles of reaching the wait-for-data point, loading stops, err_stall is set and the block moves on to the busy wait.
- R7: After loading ends, chip-enable is released and the block waits SETTLE_CYC cycles. It then samples mem_rdy every cycle and pulses done for one cycle when mem_rdy is high.
- R8: If mem_rdy stays low for TIMEOUT_CYC polled cycles, err_timeout is set and done pulses.
- R9: A read command holds mem_ce_n and mem_oe_n low and mem_we_n high for RD_ACC_CYC cycles. It then returns mem_din on rd_data with a one-cycle rd_valid pulse. Output-enable is never low while write-enable is low or the data bus is driven.
- R10: cmd_ready is high only when the block is idle, and wr_ready only while it waits for a write byte. A command offered while busy is ignored and causes no pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_write | input | 1 | 1 = page write, 0 = single read |
| cmd_addr | input | 13 | Start address |
| cmd_len | input | 5 | Byte count minus one |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | 8 | Read data |
| done | output | 1 | One-cycle end-of-write pulse |
| err_page | output | 1 | Page end reached with bytes left |
| err_stall | output | 1 | Write stream stalled too long |
| err_timeout | output | 1 | Ready not seen before timeout |
| mem_addr | output | 13 | Memory address pins |
| mem_dout | output | 8 | Data driven to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 8 | Data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rdy | input | 1 | Device ready (low while busy) |

## Verification
A wrong sequencer state shows on the memory pins in the same cycle it is taken, because every pin comes straight from a register. A phase counter that is off by one shortens or lengthens a write-enable pulse or a spacing gap by exactly one cycle. A wrong address step moves mem_addr on the next load. A bad poll or timeout count moves done or err_timeout by a cycle. The bench predicts every pin on every cycle, so any of these faults is seen at the first cycle where it differs.

// File: rtl/eepg_pkg.sv
package eepg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AWAIT,
        ST_WLOW,
        ST_WHIGH,
        ST_SETTLE,
        ST_POLL,
        ST_READ
    } eepg_state_e;
endpackage

// File: rtl/eepg_countdown.sv
module eepg_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val_q <= '0;
        else if (load)
            val_q <= load_val;
        else if (dec && val_q != '0)
            val_q <= val_q - W'(1);
    end

    assign zero = (val_q == '0);
endmodule

// File: rtl/eepg_span.sv
module eepg_span #(
    parameter int PAGE_BITS = 5
) (
    input  logic [PAGE_BITS-1:0] offset,
    input  logic [PAGE_BITS:0]   left,
    output logic                 last_byte,
    output logic                 page_end
);
    assign last_byte = (left == (PAGE_BITS+1)'(1));
    assign page_end  = &offset;
endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog
    import eepg_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int PAGE_BITS   = 5,
    parameter int WE_LOW_CYC  = 19,
    parameter int WE_HIGH_CYC = 13,
    parameter int GAP_MAX_CYC = 10000,
    parameter int SETTLE_CYC  = 28,
    parameter int TIMEOUT_CYC = 687500,
    parameter int RD_ACC_CYC  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_write,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [PAGE_BITS-1:0] cmd_len,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 done,
    output logic                 err_page,
    output logic                 err_stall,
    output logic                 err_timeout,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dout,
    output logic                 mem_dout_en,
    input  logic [DATA_W-1:0]    mem_din,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    input  logic                 mem_rdy
);
    localparam int MAX_A  = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
    localparam int MAX_B  = (SETTLE_CYC > RD_ACC_CYC) ? SETTLE_CYC : RD_ACC_CYC;
    localparam int PH_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int GAP_W  = $clog2(GAP_MAX_CYC + 1);
    localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);
    localparam int PG_W   = ADDR_W - PAGE_BITS;

    typedef struct packed {
        eepg_state_e          st;
        logic [PH_W-1:0]      ph;
        logic [GAP_W-1:0]     gap;
        logic                 first;
        logic [PAGE_BITS:0]   left;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    dout;
        logic                 dout_en;
        logic                 ce_n;
        logic                 oe_n;
        logic                 we_n;
        logic                 done;
        logic                 rd_valid;
        logic [DATA_W-1:0]    rd_data;
        logic                 err_pg;
        logic                 err_st;
        logic                 err_to;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, ph: '0, gap: '0, first: 1'b0, left: '0, addr: '0,
        dout: '0, dout_en: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
        done: 1'b0, rd_valid: 1'b0, rd_data: '0,
        err_pg: 1'b0, err_st: 1'b0, err_to: 1'b0
    };

    regs_t r_d, r_q;
    logic  to_load, to_dec, to_zero;
    logic  last_byte, page_end;

    eepg_span #(.PAGE_BITS(PAGE_BITS)) u_span (
        .offset   (r_q.addr[PAGE_BITS-1:0]),
        .left     (r_q.left),
        .last_byte(last_byte),
        .page_end (page_end)
    );

    eepg_countdown #(.W(TO_W)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (to_load),
        .load_val(TO_W'(TIMEOUT_CYC - 1)),
        .dec     (to_dec),
        .zero    (to_zero)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.rd_valid = 1'b0;
        to_load      = 1'b0;
        to_dec       = 1'b0;
        case (r_q.st)
            ST_IDLE: if (cmd_valid) begin
                r_d.err_pg = 1'b0;
                r_d.err_st = 1'b0;
                r_d.err_to = 1'b0;
                r_d.addr   = cmd_addr;
                if (cmd_write) begin
                    r_d.st    = ST_AWAIT;
                    r_d.left  = {1'b0, cmd_len} + (PAGE_BITS+1)'(1);
                    r_d.first = 1'b1;
                    r_d.gap   = GAP_W'(GAP_MAX_CYC - 1);
                end else begin
                    r_d.st   = ST_READ;
                    r_d.ce_n = 1'b0;
                    r_d.oe_n = 1'b0;
                    r_d.ph   = PH_W'(RD_ACC_CYC - 1);
                end
            end
            ST_AWAIT: begin
                if (wr_valid) begin
                    r_d.st      = ST_WLOW;
                    r_d.we_n    = 1'b0;
                    r_d.ce_n    = 1'b0;
                    r_d.dout    = wr_data;
                    r_d.dout_en = 1'b1;
                    r_d.ph      = PH_W'(WE_LOW_CYC - 1);
                end else if (!r_q.first) begin
                    if (r_q.gap == '0) begin
                        r_d.err_st = 1'b1;
                        r_d.st     = ST_SETTLE;
                        r_d.ph     = PH_W'(SETTLE_CYC - 1);
                    end else begin
                        r_d.gap = r_q.gap - GAP_W'(1);
                    end
                end
            end
            ST_WLOW: begin
                if (r_q.ph == '0) begin
                    r_d.we_n = 1'b1;
                    r_d.left = r_q.left - (PAGE_BITS+1)'(1);
                    if (last_byte || page_end) begin
                        r_d.err_pg = !last_byte;
                        r_d.st     = ST_SETTLE;
                        r_d.ph     = PH_W'(SETTLE_CYC - 1);
                    end else begin
                        r_d.addr = r_q.addr + ADDR_W'(1);
                        r_d.st   = ST_WHIGH;
                        r_d.ph   = PH_W'(WE_HIGH_CYC - 1);
                    end
                end else begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end
            end
            ST_WHIGH: begin
                if (r_q.ph == '0) begin
                    r_d.st    = ST_AWAIT;
                    r_d.first = 1'b0;
                    r_d.gap   = GAP_W'(GAP_MAX_CYC - 1);
                end else begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end
            end
            ST_SETTLE: begin
                r_d.ce_n    = 1'b1;
                r_d.dout_en = 1'b0;
                if (r_q.ph == '0) begin
                    r_d.st  = ST_POLL;
                    to_load = 1'b1;
                end else begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end
            end
            ST_POLL: begin
                if (mem_rdy) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (to_zero) begin
                    r_d.err_to = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.st     = ST_IDLE;
                end else begin
                    to_dec = 1'b1;
                end
            end
            ST_READ: begin
                if (r_q.ph == '0) begin
                    r_d.rd_data  = mem_din;
                    r_d.rd_valid = 1'b1;
                    r_d.ce_n     = 1'b1;
                    r_d.oe_n     = 1'b1;
                    r_d.st       = ST_IDLE;
                end else begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign cmd_ready   = (r_q.st == ST_IDLE);
    assign wr_ready    = (r_q.st == ST_AWAIT);
    assign rd_valid    = r_q.rd_valid;
    assign rd_data     = r_q.rd_data;
    assign done        = r_q.done;
    assign err_page    = r_q.err_pg;
    assign err_stall   = r_q.err_st;
    assign err_timeout = r_q.err_to;
    assign mem_addr    = r_q.addr;
    assign mem_dout    = r_q.dout;
    assign mem_dout_en = r_q.dout_en;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_we_n    = r_q.we_n;

    // Pin-level observers for the assertions below
    logic [PH_W:0]   we_low_run_q;
    logic [PH_W:0]   we_high_run_q;
    logic [PG_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_run_q  <= '0;
            we_high_run_q <= (PH_W+1)'(WE_HIGH_CYC);
            page_q        <= '0;
        end else begin
            we_low_run_q  <= mem_we_n ? '0 : we_low_run_q + (PH_W+1)'(1);
            if (!mem_we_n)
                we_high_run_q <= '0;
            else if (we_high_run_q != (PH_W+1)'(WE_HIGH_CYC))
                we_high_run_q <= we_high_run_q + (PH_W+1)'(1);
            if (cmd_valid && cmd_ready)
                page_q <= cmd_addr[ADDR_W-1:PAGE_BITS];
        end
    end

    assert_we_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> we_low_run_q == (PH_W+1)'(WE_LOW_CYC));

    assert_we_low_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dout_en));

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && we_low_run_q != '0) |-> $stable(mem_addr) && $stable(mem_dout));

    assert_we_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> we_high_run_q == (PH_W+1)'(WE_HIGH_CYC));

    assert_same_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> mem_addr[ADDR_W-1:PAGE_BITS] == page_q);

    assert_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dout_en));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/eeprom_page_prog_bench.sv
module eeprom_page_prog_bench;
    localparam int P_WL = 3, P_WH = 2, P_GAP = 6, P_SET = 3, P_TO = 40, P_RD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [12:0] cmd_addr = '0;
    logic [4:0] cmd_len = '0;
    logic wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic mem_rdy = 1'b1;
    logic cmd_ready, wr_ready, rd_valid, done, err_page, err_stall, err_timeout;
    logic [7:0] rd_data, mem_dout, mem_din;
    logic [12:0] mem_addr;
    logic mem_dout_en, mem_ce_n, mem_oe_n, mem_we_n;

    int n_cmp = 0, n_bad = 0, n_fall = 0;

    always #4 clk = ~clk;

    // Behavioural device read data: a fixed function of the address
    function automatic logic [7:0] dev_byte(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction
    assign mem_din = dev_byte(mem_addr);

    eeprom_page_prog #(
        .WE_LOW_CYC(P_WL), .WE_HIGH_CYC(P_WH), .GAP_MAX_CYC(P_GAP),
        .SETTLE_CYC(P_SET), .TIMEOUT_CYC(P_TO), .RD_ACC_CYC(P_RD)
    ) u_eeprom_page_prog (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .err_page(err_page), .err_stall(err_stall), .err_timeout(err_timeout),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_rdy(mem_rdy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Reference model: phases 0 idle, 1 wait byte, 2 WE low, 3 WE high,
    // 4 settle, 5 poll, 6 read
    int m_ph, m_t, m_gap, m_left, m_to;
    bit m_first, m_we, m_ce, m_oe, m_den, m_done, m_rv, m_eb, m_es, m_et;
    logic [12:0] m_addr;
    logic [7:0] m_dout, m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= 0; m_t <= 0; m_gap <= 0; m_left <= 0; m_to <= 0; m_first <= 0;
            m_we <= 1; m_ce <= 1; m_oe <= 1; m_den <= 0; m_done <= 0; m_rv <= 0;
            m_eb <= 0; m_es <= 0; m_et <= 0; m_addr <= '0; m_dout <= '0; m_rd <= '0;
        end else begin
            m_done <= 0;
            m_rv <= 0;
            case (m_ph)
                0: if (cmd_valid) begin
                    m_eb <= 0; m_es <= 0; m_et <= 0;
                    m_addr <= cmd_addr;
                    if (cmd_write) begin
                        m_ph <= 1; m_left <= int'(cmd_len) + 1; m_first <= 1; m_gap <= P_GAP - 1;
                    end else begin
                        m_ph <= 6; m_ce <= 0; m_oe <= 0; m_t <= P_RD - 1;
                    end
                end
                1: if (wr_valid) begin
                    m_ph <= 2; m_we <= 0; m_ce <= 0; m_den <= 1; m_dout <= wr_data; m_t <= P_WL - 1;
                end else if (!m_first) begin
                    if (m_gap == 0) begin m_es <= 1; m_ph <= 4; m_t <= P_SET - 1; end
                    else m_gap <= m_gap - 1;
                end
                2: if (m_t == 0) begin
                    m_we <= 1; m_left <= m_left - 1;
                    if (m_left == 1) begin m_ph <= 4; m_t <= P_SET - 1; end
                    else if (m_addr % 32 == 31) begin m_eb <= 1; m_ph <= 4; m_t <= P_SET - 1; end
                    else begin m_addr <= m_addr + 1; m_ph <= 3; m_t <= P_WH - 1; end
                end else m_t <= m_t - 1;
                3: if (m_t == 0) begin m_ph <= 1; m_first <= 0; m_gap <= P_GAP - 1; end
                   else m_t <= m_t - 1;
                4: begin
                    m_ce <= 1; m_den <= 0;
                    if (m_t == 0) begin m_ph <= 5; m_to <= P_TO - 1; end
                    else m_t <= m_t - 1;
                end
                5: if (mem_rdy) begin m_done <= 1; m_ph <= 0; end
                   else if (m_to == 0) begin m_et <= 1; m_done <= 1; m_ph <= 0; end
                   else m_to <= m_to - 1;
                6: if (m_t == 0) begin
                    m_rd <= dev_byte(m_addr); m_rv <= 1; m_ce <= 1; m_oe <= 1; m_ph <= 0;
                end else m_t <= m_t - 1;
                default: m_ph <= 0;
            endcase
        end
    end

    // Compare every output on every falling edge
    bit prev_we = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}, 4'b1110);
            chk("R1 reset status", {cmd_ready, done, rd_valid, err_page, err_stall, err_timeout}, 6'b100000);
        end else begin
            chk("R10 cmd_ready", cmd_ready, m_ph == 0);
            chk("R10 wr_ready", wr_ready, m_ph == 1);
            chk(m_ph == 3 ? "R3 we_n spacing" : "R2 we_n", mem_we_n, m_we);
            chk("R2 ce_n", mem_ce_n, m_ce);
            chk("R9 oe_n", mem_oe_n, m_oe);
            chk("R2 dout_en", mem_dout_en, m_den);
            if (!m_ce) chk("R2 addr", mem_addr, m_addr);
            if (m_den) chk("R2 dout", mem_dout, m_dout);
            chk("R7 done", done, m_done);
            chk("R9 rd_valid", rd_valid, m_rv);
            if (m_rv) chk("R9 rd_data", rd_data, m_rd);
            chk("R5 err_page", err_page, m_eb);
            chk("R6 err_stall", err_stall, m_es);
            chk("R8 err_timeout", err_timeout, m_et);
            if (prev_we && !mem_we_n) n_fall++;
        end
        prev_we = mem_we_n;
    end

    task automatic do_read(input logic [12:0] a);
        cmd_valid = 1; cmd_write = 0; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 0;
        repeat (P_RD + 3) @(negedge clk);
    endtask

    // offer: bytes handed over; rdy_after < 0 keeps the device busy
    task automatic do_write(input logic [12:0] a, input int len, input int offer,
                            input int gap, input int rdy_after, input bit poke,
                            input int exp_loads);
        int k;
        n_fall = 0;
        mem_rdy = 0;
        cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_len = 5'(len - 1);
        @(negedge clk);
        cmd_valid = 0;
        for (int i = 0; i < offer; i++) begin
            wr_valid = 1; wr_data = 8'(8'h3C + i * 7);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 0;
            if (poke && i == 0) begin
                // R10: a read offered while busy must leave the pins untouched
                cmd_valid = 1; cmd_write = 0; cmd_addr = 13'h1ABC;
                @(negedge clk);
                cmd_valid = 0;
            end
            repeat (gap) @(negedge clk);
        end
        if (rdy_after >= 0) begin
            repeat (rdy_after) @(negedge clk);
            mem_rdy = 1;
        end
        k = 0;
        while (!done && k < 400) begin @(negedge clk); k++; end
        chk("R7 done seen", done, 1);
        chk("R4 load count", n_fall, exp_loads);
        mem_rdy = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        do_read(13'h0123);                          // R9
        do_write(13'h0040, 4, 4, 0, 10, 0, 4);      // R2 R4 R7 back-to-back
        do_write(13'h0205, 3, 3, 2, 12, 1, 3);      // R3 R10 spaced, busy poke
        do_write(13'h0100, 32, 32, 0, 8, 0, 32);    // R4 full page
        do_write(13'h005E, 5, 2, 0, 10, 0, 2);      // R5 page end
        do_write(13'h0300, 3, 1, 0, 20, 0, 1);      // R6 stall
        do_write(13'h0400, 1, 1, 0, -1, 0, 1);      // R8 timeout
        do_write(13'h1FE0, 1, 1, 0, 5, 0, 1);       // R4 single byte
        do_read(13'h1FFF);                          // R9
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule